// File: doc/BRIEF.md
# Reply Buffer Distributor

This block gathers 32-bit reply words from a host and hands them out to a set of per-tag transmit channels. Every tag supplies its reply as a pair of words. A tag with nothing to send in its second word fills it with zero. Writes land in a word store in arrival order. Nothing is passed on until the host pulses a commit strobe.

On an accepted commit, each channel that owns a complete word pair loads a 64-bit shift register. A divider then produces a slow bit-rate tick, slow or fast as chosen by a rate input. All loaded channels shift out their registers least significant bit first, in lockstep, one bit per tick. Each active channel raises a valid flag while it shifts. A shared busy flag covers the whole frame. The block also latches the number of tags that supplied a reply, and the word pointer restarts so the next round begins at channel 0.

Top module: `reply_fanout`

## Requirements
- R1: After a synchronous reset, busy, bit_tick, every ch_valid and every ch_bit are 0 and tag_count is 0.
- R2: For channel k, the word accepted in write slot 2k fills bits 63:32 of its shift register and the word in slot 2k+1 fills bits 31:0. ch_bit[k] presents register bit 0 first, then bit 1, and so on up to bit 63.
- R3: Each bit is held for exactly DIV_SLOW clock cycles when rate_fast is 0 and DIV_FAST cycles when it is 1. Bit 0 appears in the cycle after the clock edge that accepts the commit.
- R4: Every channel that owns a complete pair holds ch_valid high for exactly 64 bit periods. busy covers the same cycles and falls after the last bit. bit_tick pulses only while busy.
- R5: A channel without a complete word pair keeps ch_valid and ch_bit at 0 for the whole frame.
- R6: tag_count takes the number of complete word pairs on the commit edge. It holds that value until the next accepted commit or reset, and it equals the number of valid channels while busy.
- R7: A write is dropped when busy is high, when all 2*NUM_CH slots are already filled, or when it arrives in the same cycle as commit.
- R8: A commit with no complete word pair (zero or one word stored) is ignored: busy stays low, tag_count is unchanged and the stored word is kept.
- R9: An accepted commit empties the word store, so the next round's first write goes to slot 0 and a leftover odd word is discarded.
- R10: A reset during a frame stops it at once and clears the stored words, the write pointer and the tag count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_data | input | WORD_W | Host reply word |
| commit | input | 1 | Single-cycle strobe: all tags have written |
| rate_fast | input | 1 | 0 = slow bit rate (DIV_SLOW), 1 = fast bit rate (DIV_FAST) |
| ch_bit | output | NUM_CH | Serial bit of each channel |
| ch_valid | output | NUM_CH | Channel is sending its reply |
| busy | output | 1 | A frame is being shifted out |
| bit_tick | output | 1 | Single-cycle bit-rate enable, the shift edge |
| tag_count | output | $clog2(NUM_CH+1) | Number of tags in the last committed round |

## Verification
The assertions assume that rate_fast does not change while busy is high and that commit is a single-cycle pulse. The bench changes the rate only together with a commit, and it drops every strobe after one cycle. The bench also drives writes in the middle of a frame, writes in the commit cycle, and commits with no complete pair, so that the rejection paths are exercised. It compares every output against a word-slot model that it advances only on writes the requirements say are accepted.

// File: rtl/rfo_pkg.sv
package rfo_pkg;
   // Words that make up one tag reply; the channel register is this many words wide.
   localparam int unsigned WORDS_PER_TAG = 2;

   typedef enum logic {
      RATE_SLOW = 1'b0,
      RATE_FAST = 1'b1
   } rate_e;
endpackage

// File: rtl/rfo_word_store.sv
module rfo_word_store #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned PTR_W  = 4,
   parameter int unsigned CNT_W  = 3
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               wr_accept,
   input  logic [WORD_W-1:0]                  wr_data,
   input  logic                               clear,
   output logic [2*NUM_CH-1:0][WORD_W-1:0]    words,
   output logic [CNT_W-1:0]                   pairs
);
   localparam int unsigned SLOTS = rfo_pkg::WORDS_PER_TAG * NUM_CH;
   localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   logic [PTR_W-1:0] ptr;
   logic             room;

   assign room  = (ptr < PTR_W'(SLOTS));
   assign pairs = CNT_W'(ptr >> 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr   <= '0;
         words <= '0;
      end else if (clear) begin
         ptr <= '0;
      end else if (wr_accept && room) begin
         words[ptr[IDX_W-1:0]] <= wr_data;
         ptr                   <= ptr + PTR_W'(1);
      end
   end
endmodule

// File: rtl/rfo_rate_gen.sv
module rfo_rate_gen #(
   parameter int unsigned DIV_SLOW = 5000,
   parameter int unsigned DIV_FAST = 2500
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic restart,
   input  logic fast,
   output logic tick
);
   localparam int unsigned CW = $clog2(DIV_SLOW);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim  = (fast == rfo_pkg::RATE_FAST) ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
   assign tick = run && (cnt == lim);

   always_ff @(posedge clk) begin
      if (rst || restart || !run || tick) cnt <= '0;
      else                                cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/rfo_lane.sv
module rfo_lane #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              take,
   input  logic [WORD_W-1:0] hi_word,
   input  logic [WORD_W-1:0] lo_word,
   input  logic              shift,
   input  logic              finish,
   output logic              bit_o,
   output logic              valid_o
);
   localparam int unsigned REG_W = rfo_pkg::WORDS_PER_TAG * WORD_W;

   logic [REG_W-1:0] sreg;
   logic             live;

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg <= '0;
         live <= 1'b0;
      end else if (load) begin
         sreg <= take ? {hi_word, lo_word} : '0;
         live <= take;
      end else begin
         if (shift)  sreg <= sreg >> 1;
         if (finish) live <= 1'b0;
      end
   end

   assign bit_o   = live & sreg[0];
   assign valid_o = live;
endmodule

// File: rtl/reply_fanout.sv
module reply_fanout #(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned DIV_SLOW = 5000,
   parameter int unsigned DIV_FAST = 2500
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            wr_en,
   input  logic [WORD_W-1:0]               wr_data,
   input  logic                            commit,
   input  logic                            rate_fast,
   output logic [NUM_CH-1:0]               ch_bit,
   output logic [NUM_CH-1:0]               ch_valid,
   output logic                            busy,
   output logic                            bit_tick,
   output logic [$clog2(NUM_CH+1)-1:0]     tag_count
);
   localparam int unsigned BUF_W = rfo_pkg::WORDS_PER_TAG * WORD_W;
   localparam int unsigned PTR_W = $clog2(rfo_pkg::WORDS_PER_TAG * NUM_CH + 1);
   localparam int unsigned CNT_W = $clog2(NUM_CH + 1);
   localparam int unsigned BIT_W = $clog2(BUF_W);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("reply_fanout: NUM_CH must be at least 1");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("reply_fanout: WORD_W must be at least 1");
      end
      if (DIV_FAST < 2) begin : g_bad_fast
         $error("reply_fanout: DIV_FAST must be at least 2");
      end
      if (DIV_SLOW < DIV_FAST) begin : g_bad_slow
         $error("reply_fanout: DIV_SLOW must not be below DIV_FAST");
      end
   endgenerate

   logic [2*NUM_CH-1:0][WORD_W-1:0] words;
   logic [CNT_W-1:0]                pairs;
   logic                            go;
   logic                            wr_accept;
   logic                            last;
   logic                            busy_q;
   logic [BIT_W-1:0]                bit_idx;
   logic [CNT_W-1:0]                count_q;

   assign go        = commit && !busy_q && (pairs != '0);
   assign wr_accept = wr_en && !busy_q && !commit;
   assign last      = bit_tick && (bit_idx == BIT_W'(BUF_W - 1));

   rfo_word_store #(
      .NUM_CH (NUM_CH),
      .WORD_W (WORD_W),
      .PTR_W  (PTR_W),
      .CNT_W  (CNT_W)
   ) u_store (
      .clk       (clk),
      .rst       (rst),
      .wr_accept (wr_accept),
      .wr_data   (wr_data),
      .clear     (go),
      .words     (words),
      .pairs     (pairs)
   );

   rfo_rate_gen #(
      .DIV_SLOW (DIV_SLOW),
      .DIV_FAST (DIV_FAST)
   ) u_rate (
      .clk     (clk),
      .rst     (rst),
      .run     (busy_q),
      .restart (go),
      .fast    (rate_fast),
      .tick    (bit_tick)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q  <= 1'b0;
         bit_idx <= '0;
         count_q <= '0;
      end else if (go) begin
         busy_q  <= 1'b1;
         bit_idx <= '0;
         count_q <= pairs;
      end else if (bit_tick) begin
         bit_idx <= bit_idx + BIT_W'(1);
         if (last) busy_q <= 1'b0;
      end
   end

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
         logic take;
         assign take = (CNT_W'(k) < pairs);

         rfo_lane #(
            .WORD_W (WORD_W)
         ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .load    (go),
            .take    (take),
            .hi_word (words[2*k]),
            .lo_word (words[2*k+1]),
            .shift   (bit_tick),
            .finish  (last),
            .bit_o   (ch_bit[k]),
            .valid_o (ch_valid[k])
         );
      end
   endgenerate

   assign busy      = busy_q;
   assign tag_count = count_q;
endmodule

// File: rtl/reply_fanout_chk.sv
module reply_fanout_chk #(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned DIV_SLOW = 5000,
   parameter int unsigned DIV_FAST = 2500
) (
   input logic              clk,
   input logic              rst,
   input logic              rate_fast,
   input logic [NUM_CH-1:0] ch_bit,
   input logic [NUM_CH-1:0] ch_valid,
   input logic              busy,
   input logic              bit_tick,
   input logic [CNT_W-1:0]  tag_count
);
   localparam int unsigned GW = $clog2(DIV_SLOW) + 1;

   logic [GW-1:0] gap;
   logic [GW-1:0] want;

   always_ff @(posedge clk) begin
      if (rst || !busy || bit_tick) gap <= '0;
      else                          gap <= gap + GW'(1);
   end

   assign want = rate_fast ? GW'(DIV_FAST - 1) : GW'(DIV_SLOW - 1);

   // R1: outputs quiet right after reset
   a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!busy && ch_valid == '0 && ch_bit == '0 && tag_count == '0));

   // R3: serial bits only move on a tick
   a_r3_bits_hold: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && !$past(bit_tick)) |-> $stable(ch_bit));

   // R3: tick spacing equals the selected division
   a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
      bit_tick |-> (gap == want));

   // R4: valid and tick live inside busy
   a_r4_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
      (ch_valid != '0) |-> busy);

   a_r4_tick_needs_busy: assert property (@(posedge clk) disable iff (rst)
      bit_tick |-> busy);

   a_r4_valid_steady: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(ch_valid));

   // R5: idle channels never drive a one
   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      ((ch_bit & ~ch_valid) == '0));

   // R6: count moves only when a frame starts, and matches active lanes
   a_r6_count_holds: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$rose(busy)) |-> $stable(tag_count));

   a_r6_valid_matches_count: assert property (@(posedge clk) disable iff (rst)
      busy |-> ($countones(ch_valid) == int'(tag_count)));
endmodule

bind reply_fanout reply_fanout_chk #(
   .NUM_CH   (NUM_CH),
   .CNT_W    (CNT_W),
   .DIV_SLOW (DIV_SLOW),
   .DIV_FAST (DIV_FAST)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rate_fast (rate_fast),
   .ch_bit    (ch_bit),
   .ch_valid  (ch_valid),
   .busy      (busy),
   .bit_tick  (bit_tick),
   .tag_count (tag_count)
);

// File: tb/tb_reply_fanout.sv
`timescale 1ns/1ps
module tb_reply_fanout;
   localparam int N  = 4;
   localparam int WW = 32;
   localparam int DS = 8;
   localparam int DF = 4;
   localparam int CW = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst;
   logic          wr_en;
   logic [WW-1:0] wr_data;
   logic          commit;
   logic          rate_fast;
   logic [N-1:0]  ch_bit;
   logic [N-1:0]  ch_valid;
   logic          busy;
   logic          bit_tick;
   logic [CW-1:0] tag_count;

   always #2.5 clk = ~clk;

   reply_fanout #(
      .NUM_CH(N), .WORD_W(WW), .DIV_SLOW(DS), .DIV_FAST(DF)
   ) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .commit(commit),
      .rate_fast(rate_fast), .ch_bit(ch_bit), .ch_valid(ch_valid), .busy(busy),
      .bit_tick(bit_tick), .tag_count(tag_count)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [WW-1:0] m_words [2*N];
   int            m_ptr   = 0;
   int            m_count = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 2*N; i++) m_words[i] = '0;
      m_ptr   = 0;
      m_count = 0;
   endtask

   // Writes one word; called at a negedge while the block is idle.
   task automatic put(input logic [WW-1:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (m_ptr < 2*N) begin
         m_words[m_ptr] = d;
         m_ptr++;
      end
   endtask

   function automatic logic [63:0] exp_reg(input int k);
      return {m_words[2*k], m_words[2*k+1]};
   endfunction

   // Commits and follows the whole frame cycle by cycle.
   task automatic commit_run(input bit fast, input bit poke, input bit write_in_commit);
      int            pairs;
      int            div;
      logic [63:0]   regs [N];
      logic [N-1:0]  ev;
      logic [N-1:0]  eb;
      pairs = m_ptr / 2;
      rate_fast = fast;
      commit    = 1'b1;
      if (write_in_commit) begin
         wr_en   = 1'b1;
         wr_data = $urandom();
      end
      @(negedge clk);
      commit = 1'b0;
      wr_en  = 1'b0;
      if (pairs == 0) begin
         chk(busy == 1'b0, "R8", "busy after empty commit", 64'(busy), 64'd0);
         chk(tag_count == CW'(m_count), "R8", "tag_count kept", 64'(tag_count), 64'(m_count));
         return;
      end
      for (int k = 0; k < N; k++) regs[k] = (k < pairs) ? exp_reg(k) : 64'd0;
      m_count = pairs;
      m_ptr   = 0;
      div = fast ? DF : DS;
      ev = '0;
      for (int k = 0; k < N; k++) ev[k] = (k < pairs);
      chk(tag_count == CW'(pairs), "R6", "tag_count at frame start", 64'(tag_count), 64'(pairs));
      for (int c = 0; c < 64*div; c++) begin
         int b;
         b = c / div;
         eb = '0;
         for (int k = 0; k < N; k++) eb[k] = ev[k] & regs[k][b];
         chk(ch_bit == eb, "R2 R3", $sformatf("ch_bit cycle %0d bit %0d", c, b), 64'(ch_bit), 64'(eb));
         chk(ch_valid == ev, "R4 R5", $sformatf("ch_valid cycle %0d", c), 64'(ch_valid), 64'(ev));
         chk(busy == 1'b1, "R4", $sformatf("busy cycle %0d", c), 64'(busy), 64'd1);
         if (poke && c == 3) begin
            wr_en   = 1'b1;
            wr_data = $urandom();
         end
         if (poke && c == 4) wr_en = 1'b0;
         @(negedge clk);
      end
      chk(busy == 1'b0, "R4", "busy after last bit", 64'(busy), 64'd0);
      chk(ch_valid == '0, "R4", "valid after last bit", 64'(ch_valid), 64'd0);
      chk(tag_count == CW'(pairs), "R6", "tag_count held after frame", 64'(tag_count), 64'(pairs));
   endtask

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5eed);
      rst = 1'b1; wr_en = 1'b0; wr_data = '0; commit = 1'b0; rate_fast = 1'b0;
      model_clear();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk(busy == 1'b0 && bit_tick == 1'b0, "R1", "busy/tick after reset", 64'({busy, bit_tick}), 64'd0);
      chk(ch_valid == '0 && ch_bit == '0, "R1", "lanes after reset", 64'({ch_valid, ch_bit}), 64'd0);
      chk(tag_count == '0, "R1", "tag_count after reset", 64'(tag_count), 64'd0);

      // R8: one word only, commit ignored, word kept
      put(32'hA5A5_0001);
      commit_run(1'b0, 1'b0, 1'b0);
      // second word zero-filled; only channel 0 active (R5)
      put(32'h0000_0000);
      commit_run(1'b0, 1'b0, 1'b0);

      // all channels, fast rate, write poked mid-frame (R7)
      for (int i = 0; i < 2*N; i++) put($urandom());
      commit_run(1'b1, 1'b1, 1'b0);

      // R7: overfull, extra words dropped
      for (int i = 0; i < 2*N + 2; i++) put(32'hC000_0000 | 32'(i));
      commit_run(1'b1, 1'b0, 1'b0);

      // R9 and R7: three words plus write in commit cycle -> one tag
      put(32'h1111_1111); put(32'h2222_2222); put(32'h3333_3333);
      commit_run(1'b0, 1'b0, 1'b1);
      // R9: next round starts at slot 0
      put(32'hDEAD_BEEF); put(32'h0BAD_F00D);
      commit_run(1'b1, 1'b0, 1'b0);

      // R8: commit with nothing stored
      commit_run(1'b0, 1'b0, 1'b0);

      // R10: reset in mid-frame
      for (int i = 0; i < 4; i++) put($urandom());
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
      repeat (20) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_clear();
      chk(busy == 1'b0 && ch_valid == '0, "R10", "frame stopped by reset", 64'({busy, ch_valid}), 64'd0);
      chk(ch_bit == '0 && tag_count == '0, "R10", "bits/count cleared", 64'({ch_bit, tag_count}), 64'd0);
      put(32'h7777_0000); put(32'h0000_8888);
      commit_run(1'b0, 1'b0, 1'b0);

      // constrained random rounds
      for (int r = 0; r < 6; r++) begin
         int nw;
         nw = $urandom_range(0, 2*N + 2);
         for (int i = 0; i < nw; i++) put($urandom());
         commit_run(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R4 watchdog actual=timeout expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule